// File: doc/BRIEF.md
# Single-Bus Datapath with Flat Control Word

This block is a datapath built around one shared main bus. In every clock cycle a flat control word supplies all the control bits the datapath needs. Those bits cover which unit drives the bus, the two register-file read addresses, the write address and write enable, the ALU function, the shift function, the M-register load, and the memory address and write strobe. Sequencing and instruction decoding sit outside the block. A field that an operation does not need is parked at a value that changes no state.

Five units can drive the bus: the ALU/shifter result, the M register, an external input, read port A of the register file, and a small data memory. The register file has two read ports, and both feed the ALU. Data can only be written into the register file and the memory from the bus. The M register loads the shifted ALU result whatever is on the bus. The bus is guarded so that only one driver is active at a time. A conflict is flagged and forces the bus to zero.

Top module: `sbus_datapath`

## Requirements
- R1: `src_en_i` is a bus enable vector with bit 0 = ALU/shifter result, bit 1 = M register, bit 2 = external input `ext_i`, bit 3 = register-file read port A, and bit 4 = memory word at `mem_addr_i`. With exactly one bit set, `bus_o` equals that source in the same cycle.
- R2: With no enable bit set, `bus_o` is zero.
- R3: With two or more enable bits set, `bus_o` is zero and `bus_err_o` is 1 in the same cycle. Otherwise `bus_err_o` is 0.
- R4: The register file has R registers of N bits and two independent combinational read ports, A addressed by `ra1_i` and B addressed by `ra2_i`. Any register can be read on either port, including the same register on both ports.
- R5: When `wr_i` is 1, the bus value is written to register `wa_i` on the rising edge and can be read in the next cycle. When `wr_i` is 0, no register changes.
- R6: `alu_op_i` selects the ALU function with A = port A and B = port B: 000 gives A, 001 gives B, 010 gives all zeros, 011 gives all ones, 100 gives A+B, 101 gives A-B, 110 gives A AND B, and 111 gives A OR B. Arithmetic wraps modulo 2^N.
- R7: `shf_op_i` acts on the ALU value. Bit 2 = 0 passes the value through unchanged. 100 shifts left by one with zero fill, and 101 shifts right by one with zero fill. 110 shifts left with the LSB filled from M[N-1]. 111 shifts right with the MSB filled from M[0].
- R8: When `ldm_i` is 1, M loads the shifted ALU result on the rising edge, independent of the bus source. When `ldm_i` is 0, M holds its value.
- R9: The memory has 16 words of N bits, addressed by the 4-bit `mem_addr_i`. When `mem_wr_i` is 1, the bus value is written on the rising edge. Reads are combinational.
- R10: Reset (`rst_ni` low) clears all registers, all memory words and M to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_i | input | N | External input value |
| src_en_i | input | 5 | Bus source enables |
| ra1_i | input | log2 R | Read port A address |
| ra2_i | input | log2 R | Read port B address |
| wa_i | input | log2 R | Register write address |
| wr_i | input | 1 | Register write enable |
| alu_op_i | input | 3 | ALU function code |
| shf_op_i | input | 3 | Shift function code |
| ldm_i | input | 1 | Load M register |
| mem_addr_i | input | 4 | Memory word address |
| mem_wr_i | input | 1 | Memory write enable |
| bus_o | output | N | Main bus value |
| m_o | output | N | M register contents |
| bus_err_o | output | 1 | Multiple bus drivers flagged |

## Verification
The bus value and the conflict flag are combinational. They are due in the same cycle the controls are applied, so the bench samples them one nanosecond after driving, well before the next edge. Register, memory and M updates land on the following rising edge. The bench checks their effect one cycle later, either through `m_o` or by reading the stored value back onto the bus. A scoreboard model advances its own copy of the state at the same edge, so every expected item refers to the cycle in which it is compared.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
  localparam int NSRC = 5;
  localparam int SRC_ALU = 0;
  localparam int SRC_M   = 1;
  localparam int SRC_IN  = 2;
  localparam int SRC_RF  = 3;
  localparam int SRC_MEM = 4;

  typedef enum logic [2:0] {
    OP_PASS_A = 3'b000, OP_PASS_B = 3'b001, OP_ZERO = 3'b010, OP_ONES = 3'b011,
    OP_ADD    = 3'b100, OP_SUB    = 3'b101, OP_AND  = 3'b110, OP_OR   = 3'b111
  } alu_op_e;

  typedef enum logic [2:0] {
    SH_LZ = 3'b100, SH_RZ = 3'b101, SH_LM = 3'b110, SH_RM = 3'b111
  } shf_op_e;
endpackage

// File: rtl/sbus_regfile.sv
module sbus_regfile #(
  parameter int N = 8,
  parameter int R = 8,
  localparam int AW = $clog2(R)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] ra1_i,
  input  logic [AW-1:0] ra2_i,
  input  logic [AW-1:0] wa_i,
  input  logic          wr_i,
  input  logic [N-1:0]  wdata_i,
  output logic [N-1:0]  rd_a_o,
  output logic [N-1:0]  rd_b_o
);
  logic [N-1:0] regs_q [R];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < R; i++) regs_q[i] <= '0;
    end else if (wr_i) begin
      regs_q[wa_i] <= wdata_i;
    end
  end

  assign rd_a_o = regs_q[ra1_i];
  assign rd_b_o = regs_q[ra2_i];

  // R5: a written value is on port A next cycle when addressed there
  assert_write_lands_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(wr_i) && ra1_i == $past(wa_i)) |-> rd_a_o == $past(wdata_i));
  // R4: both ports agree when pointed at the same register
  assert_ports_agree_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ra1_i == ra2_i) |-> rd_a_o == rd_b_o);
endmodule

// File: rtl/sbus_alu.sv
module sbus_alu
  import sbus_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic [N-1:0] m_i,
  input  logic [2:0]   op_i,
  input  logic [2:0]   shf_i,
  output logic [N-1:0] raw_o,
  output logic [N-1:0] res_o
);
  function automatic logic [N-1:0] alu_fn(input logic [2:0] op,
                                          input logic [N-1:0] a, input logic [N-1:0] b);
    case (alu_op_e'(op))
      OP_PASS_A: return a;
      OP_PASS_B: return b;
      OP_ZERO:   return '0;
      OP_ONES:   return '1;
      OP_ADD:    return a + b;
      OP_SUB:    return a - b;
      OP_AND:    return a & b;
      default:   return a | b;
    endcase
  endfunction

  function automatic logic [N-1:0] shf_fn(input logic [2:0] sh,
                                          input logic [N-1:0] x, input logic [N-1:0] m);
    if (!sh[2]) return x;
    case (shf_op_e'(sh))
      SH_LZ:   return {x[N-2:0], 1'b0};
      SH_RZ:   return {1'b0, x[N-1:1]};
      SH_LM:   return {x[N-2:0], m[N-1]};
      default: return {m[0], x[N-1:1]};
    endcase
  endfunction

  assign raw_o = alu_fn(op_i, a_i, b_i);
  assign res_o = shf_fn(shf_i, raw_o, m_i);
endmodule

// File: rtl/sbus_mem.sv
module sbus_mem #(
  parameter int N  = 8,
  parameter int MAW = 4,
  localparam int DEPTH = 1 << MAW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [MAW-1:0] addr_i,
  input  logic           wr_i,
  input  logic [N-1:0]   wdata_i,
  output logic [N-1:0]   rdata_o
);
  logic [N-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_i) begin
      mem_q[addr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[addr_i];

  // R9: a stored word reads back next cycle at the same address
  assert_mem_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(wr_i) && addr_i == $past(addr_i)) |-> rdata_o == $past(wdata_i));
endmodule

// File: rtl/sbus_bus.sv
module sbus_bus
  import sbus_pkg::*;
#(
  parameter int N = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] en_i,
  input  logic [N-1:0]    src_i [NSRC],
  output logic [N-1:0]    bus_o,
  output logic            err_o
);
  logic [N-1:0] merged;
  logic         multi;

  always_comb begin
    merged = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (en_i[i]) merged = merged | src_i[i];
    end
  end

  assign multi = !$onehot0(en_i);
  assign err_o = multi;
  assign bus_o = multi ? '0 : merged;

  // R2: idle bus reads zero
  assert_idle_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i == '0) |-> bus_o == '0);
  // R3: conflict flagged and bus forced to zero
  assert_conflict_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(en_i) > 1) |-> (err_o && bus_o == '0));
  // R1: single driver passes through
  assert_single_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i == (NSRC)'(1 << SRC_IN)) |-> (bus_o == src_i[SRC_IN] && !err_o));
endmodule

// File: rtl/sbus_datapath.sv
module sbus_datapath
  import sbus_pkg::*;
#(
  parameter int N   = 8,
  parameter int R   = 8,
  parameter int MAW = 4,
  localparam int AW = $clog2(R)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N-1:0]    ext_i,
  input  logic [NSRC-1:0] src_en_i,
  input  logic [AW-1:0]   ra1_i,
  input  logic [AW-1:0]   ra2_i,
  input  logic [AW-1:0]   wa_i,
  input  logic            wr_i,
  input  logic [2:0]      alu_op_i,
  input  logic [2:0]      shf_op_i,
  input  logic            ldm_i,
  input  logic [MAW-1:0]  mem_addr_i,
  input  logic            mem_wr_i,
  output logic [N-1:0]    bus_o,
  output logic [N-1:0]    m_o,
  output logic            bus_err_o
);
  logic [N-1:0] rd_a, rd_b, alu_raw, alu_res, mem_rd, m_q, bus;
  logic [N-1:0] srcs [NSRC];
  logic         conflict;

  sbus_regfile #(.N(N), .R(R)) u_rf (
    .clk_i(clk_i), .rst_ni(rst_ni), .ra1_i(ra1_i), .ra2_i(ra2_i),
    .wa_i(wa_i), .wr_i(wr_i), .wdata_i(bus), .rd_a_o(rd_a), .rd_b_o(rd_b));

  sbus_alu #(.N(N)) u_alu (
    .a_i(rd_a), .b_i(rd_b), .m_i(m_q), .op_i(alu_op_i), .shf_i(shf_op_i),
    .raw_o(alu_raw), .res_o(alu_res));

  sbus_mem #(.N(N), .MAW(MAW)) u_mem (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(mem_addr_i), .wr_i(mem_wr_i),
    .wdata_i(bus), .rdata_o(mem_rd));

  assign srcs[SRC_ALU] = alu_res;
  assign srcs[SRC_M]   = m_q;
  assign srcs[SRC_IN]  = ext_i;
  assign srcs[SRC_RF]  = rd_a;
  assign srcs[SRC_MEM] = mem_rd;

  sbus_bus #(.N(N)) u_bus (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(src_en_i), .src_i(srcs),
    .bus_o(bus), .err_o(conflict));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    m_q <= '0;
    else if (ldm_i) m_q <= alu_res;
  end

  assign bus_o     = bus;
  assign m_o       = m_q;
  assign bus_err_o = conflict;

  // R8: M takes the shifted ALU result when loaded
  assert_m_load_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ldm_i |=> m_o == $past(alu_res));
  // R8: M holds when not loaded
  assert_m_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ldm_i |=> $stable(m_o));
  // R7: pass-through shift code leaves ALU value unchanged
  assert_no_shift_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shf_op_i[2] |-> alu_res == alu_raw);
endmodule

// File: tb/sbus_datapath_tb.sv
module sbus_datapath_tb_top;
  localparam int N = 8;
  localparam int R = 8;

  typedef struct {
    int         kind;  // 0 bus, 1 m, 2 err
    logic [7:0] exp;
    string      tag;
  } item_t;

  logic clk = 0, rst_n = 0;
  logic [7:0] ext = 0;
  logic [4:0] en = 0;
  logic [2:0] ra1 = 0, ra2 = 0, wa = 0, op = 0, sh = 0;
  logic wr = 0, ldm = 0, mwr = 0;
  logic [3:0] maddr = 0;
  logic [7:0] bus, m;
  logic err;

  int n_checks = 0, n_fail = 0;
  bit done = 0;
  item_t q[$];
  event sample_ev;

  logic [7:0] mrf [8];
  logic [7:0] mmem [16];
  logic [7:0] mm;

  always #2 clk = ~clk;

  sbus_datapath #(.N(N), .R(R)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ext_i(ext), .src_en_i(en), .ra1_i(ra1), .ra2_i(ra2),
    .wa_i(wa), .wr_i(wr), .alu_op_i(op), .shf_op_i(sh), .ldm_i(ldm),
    .mem_addr_i(maddr), .mem_wr_i(mwr), .bus_o(bus), .m_o(m), .bus_err_o(err));

  function automatic logic [7:0] mdl_alu(logic [2:0] c, logic [7:0] a, logic [7:0] b);
    if (c == 3'd0) return a;
    if (c == 3'd1) return b;
    if (c == 3'd2) return 8'h00;
    if (c == 3'd3) return 8'hFF;
    if (c == 3'd4) return 8'((a + b) & 8'hFF);
    if (c == 3'd5) return 8'((a + ~b + 1) & 8'hFF);
    if (c == 3'd6) return a & b;
    return a | b;
  endfunction

  function automatic logic [7:0] mdl_shf(logic [2:0] c, logic [7:0] x, logic [7:0] mv);
    if (c[2] == 1'b0) return x;
    if (c[1:0] == 2'd0) return x << 1;
    if (c[1:0] == 2'd1) return x >> 1;
    if (c[1:0] == 2'd2) return (x << 1) | {7'd0, mv[7]};
    return (x >> 1) | {mv[0], 7'd0};
  endfunction

  always @(sample_ev) begin
    while (q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = q.pop_front();
      act = (it.kind == 0) ? bus : (it.kind == 1) ? m : {7'd0, err};
      n_checks++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
      end
    end
  end

  task automatic step(input logic [4:0] e, input logic [2:0] a1, input logic [2:0] a2,
                      input logic [2:0] w, input logic we, input logic [2:0] o,
                      input logic [2:0] s, input logic lm, input logic [3:0] ma,
                      input logic mw, input logic [7:0] x, input string tag);
    logic [7:0] res, eb;
    int cnt;
    @(negedge clk);
    en = e; ra1 = a1; ra2 = a2; wa = w; wr = we; op = o; sh = s; ldm = lm;
    maddr = ma; mwr = mw; ext = x;
    res = mdl_shf(s, mdl_alu(o, mrf[a1], mrf[a2]), mm);
    cnt = e[0] + e[1] + e[2] + e[3] + e[4];
    eb = 8'h00;
    if (cnt == 1) begin
      if (e[0]) eb = res;
      if (e[1]) eb = mm;
      if (e[2]) eb = x;
      if (e[3]) eb = mrf[a1];
      if (e[4]) eb = mmem[ma];
    end
    q.push_back('{0, eb, tag});
    q.push_back('{1, mm, tag});
    q.push_back('{2, {7'd0, cnt > 1}, tag});
    #1 -> sample_ev;
    @(posedge clk);
    if (we) mrf[w] = eb;
    if (mw) mmem[ma] = eb;
    if (lm) mm = res;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) mrf[i] = 0;
    for (int i = 0; i < 16; i++) mmem[i] = 0;
    mm = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R10 and R2: reset state, idle bus
    step(5'b00000, 0, 0, 0, 0, 0, 0, 0, 0, 0, 8'hEE, "R10_R2 idle after reset");
    step(5'b01000, 5, 0, 0, 0, 0, 0, 0, 0, 0, 8'h00, "R10 reg cleared");
    step(5'b10000, 0, 0, 0, 0, 0, 0, 0, 7, 0, 8'h00, "R10 mem cleared");
    // R1, R5: load registers from external input
    step(5'b00100, 0, 0, 1, 1, 0, 0, 0, 0, 0, 8'h3C, "R1_R5 load r1");
    step(5'b00100, 0, 0, 2, 1, 0, 0, 0, 0, 0, 8'h05, "R1_R5 load r2");
    step(5'b00100, 0, 0, 7, 1, 0, 0, 0, 0, 0, 8'hA5, "R1_R5 load r7");
    // R4: read ports onto bus
    step(5'b01000, 2, 0, 0, 0, 0, 0, 0, 0, 0, 8'h00, "R4 read r2");
    step(5'b01000, 7, 0, 0, 0, 0, 0, 0, 0, 0, 8'h00, "R4 read r7");
    step(5'b01000, 0, 0, 0, 0, 0, 0, 0, 0, 0, 8'h00, "R4 read r0");
    // R6: every ALU op
    for (int k = 0; k < 8; k++)
      step(5'b00001, 1, 2, 0, 0, 3'(k), 0, 0, 0, 0, 8'h00, "R6 alu op");
    // R4: same register on both ports
    step(5'b00001, 7, 7, 0, 0, 3'd1, 0, 0, 0, 0, 8'h00, "R4 same reg port B");
    step(5'b00001, 7, 7, 0, 0, 3'd4, 0, 0, 0, 0, 8'h00, "R4 same reg add");
    // R8: load M while bus carries external input
    step(5'b00100, 7, 0, 0, 0, 3'd0, 0, 1, 0, 0, 8'h11, "R8 ldm independent of bus");
    // R7: shifts on r1 with M = A5
    for (int k = 3; k < 8; k++)
      step(5'b00001, 1, 0, 0, 0, 3'd0, (k == 3) ? 3'd0 : 3'(k), 0, 0, 0, 8'h00, "R7 shift");
    // R1: M onto bus; R8 hold
    step(5'b00010, 0, 0, 0, 0, 0, 0, 0, 0, 0, 8'h00, "R1_R8 M on bus");
    step(5'b00010, 0, 0, 0, 0, 0, 0, 0, 0, 0, 8'h00, "R8 M holds");
    // R5: no write when wr low
    step(5'b00100, 0, 0, 1, 0, 0, 0, 0, 0, 0, 8'hFF, "R5 wr low");
    step(5'b01000, 1, 0, 0, 0, 0, 0, 0, 0, 0, 8'h00, "R5 r1 unchanged");
    // R9: memory write and readback
    step(5'b00100, 0, 0, 0, 0, 0, 0, 0, 15, 1, 8'h5A, "R9 write mem15");
    step(5'b00100, 0, 0, 0, 0, 0, 0, 0, 0, 1, 8'hC3, "R9 write mem0");
    step(5'b10000, 0, 0, 0, 0, 0, 0, 0, 15, 0, 8'h00, "R9 read mem15");
    step(5'b10000, 0, 0, 0, 0, 0, 0, 0, 0, 0, 8'h00, "R9 read mem0");
    step(5'b10000, 0, 0, 0, 0, 0, 0, 0, 3, 0, 8'h00, "R9 read mem3");
    // R3: conflicts
    step(5'b00101, 1, 2, 3, 1, 3'd4, 0, 0, 0, 0, 8'h99, "R3 two drivers");
    step(5'b11111, 0, 0, 0, 0, 0, 0, 0, 0, 0, 8'h99, "R3 all drivers");
    step(5'b01000, 3, 0, 0, 0, 0, 0, 0, 0, 0, 8'h00, "R3 zero written on conflict");
    // R5: write then read next cycle, ALU result into register
    step(5'b00100, 0, 0, 4, 1, 0, 0, 0, 0, 0, 8'h77, "R5 write r4");
    step(5'b01000, 4, 0, 0, 0, 0, 0, 0, 0, 0, 8'h00, "R5 read r4 next");
    step(5'b00001, 1, 2, 5, 1, 3'd4, 3'd4, 0, 0, 0, 8'h00, "R5_R7 alu to r5");
    step(5'b01000, 5, 0, 0, 0, 0, 0, 0, 0, 0, 8'h00, "R5 read r5");
    step(5'b00000, 0, 0, 0, 0, 0, 0, 0, 0, 0, 8'h00, "R2 idle end");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule